// File: doc/BRIEF.md
# Leakage Rise-Time Monitor and Gating Strategy Selector

This block judges how leaky a power-gated logic domain is at the moment, and from that it advises the gating controller how aggressive runtime power gating should be. When the domain's sleep switch opens, its virtual ground starts to charge toward the supply, and an external analog comparator flags when that node passes a reference level. The block counts the clock cycles from the sleep event to the first clean 0-to-1 transition of the comparator output. That count is a stand-in for leakage: fast charging means heavy leakage, typically at high temperature. Heavy leakage means a gated unit needs only a short sleep to recover the energy spent on a power-down and power-up.

Software or a slow controller issues a start pulse to arm a measurement. The domain then enters sleep, and the block times the rise. The count and a completion pulse are presented to the outside. The count is also compared against a programmable threshold band. A short rise time selects the policy that combines compiler gating hints with L2-miss gating. A long rise time selects the policy that gates only on L2 misses and disregards compiler hints. A result inside the band keeps the present policy, so the advice does not flip on noise. A measurement that sees no edge before a programmable limit ends with a timeout flag and the long-sleep policy.

Top module: `lrm_rise_monitor`

## Requirements
- R1: During and after a synchronous active-high reset, `rise_cycles_o` is 0, `valid_o` is 0, `timeout_o` is 0 and `strategy_o` is 2'b01 (L2-miss only).
- R2: A measurement begins only when `sleep_enter_i` is sampled high while the block is armed by an earlier `start_i` pulse. A `sleep_enter_i` pulse with no preceding start produces no `valid_o` and leaves the outputs unchanged.
- R3: Let `sleep_enter_i` be sampled at edge k. If the comparator input is first sampled high at edge k+N (N >= 1), then `valid_o` is high for the cycle after edge k+N+2, `rise_cycles_o` equals N+1 and `timeout_o` is 0.
- R4: Only a 0-to-1 transition of the synchronised comparator ends a measurement. A comparator that is already high when the measurement begins does not end it.
- R5: With no edge, the measurement ends at edge k+L+1, where L is `timeout_lim_i`. At that point `valid_o` pulses, `timeout_o` is 1, `rise_cycles_o` equals L, and `strategy_o` becomes 2'b01.
- R6: A completed measurement with `rise_cycles_o` below `thr_lo_i` sets `strategy_o` to 2'b10 (compiler hints plus L2-miss). This check takes priority over R7.
- R7: A completed measurement with `rise_cycles_o` above `thr_hi_i` and not below `thr_lo_i` sets `strategy_o` to 2'b01 (L2-miss only; compiler hints ignored).
- R8: A completed measurement with `thr_lo_i` <= `rise_cycles_o` <= `thr_hi_i` leaves `strategy_o` unchanged.
- R9: The result (`rise_cycles_o`, `timeout_o`) is held until the next `start_i`. The cycle after a start pulse both are 0. A start during a running measurement abandons it and re-arms.
- R10: `valid_o` is high for exactly one cycle per completed measurement.
- R11: `strategy_o` changes only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms a new measurement and clears the held result |
| sleep_enter_i | input | 1 | Pulse marking the sleep switch of the monitored domain opening |
| cmp_async_i | input | 1 | Raw comparator output: virtual ground above reference |
| timeout_lim_i | input | 16 | Cycle limit for a measurement |
| thr_lo_i | input | 16 | Lower edge of the hysteresis band |
| thr_hi_i | input | 16 | Upper edge of the hysteresis band |
| rise_cycles_o | output | 16 | Measured rise time in cycles |
| valid_o | output | 1 | One-cycle pulse on measurement completion |
| timeout_o | output | 1 | Last measurement ended by the cycle limit |
| strategy_o | output | 2 | Advised policy: 2'b01 L2-miss only, 2'b10 compiler hints plus L2-miss |

## Verification
The comparator passes through two synchroniser flops and an edge register. A comparator first sampled at edge k+N therefore yields its result and completion pulse after edge k+N+2, while a timeout lands after edge k+L+1. The bench drives every input on falling edges and counts falling edges from the one that follows the sleep sample. For each measurement it checks three falling edges: the one before the due edge (no pulse yet, policy unchanged), the one after it (pulse, count, flag and policy), and the next one (pulse gone). A free-running counter of completion pulses, sampled on falling edges, confirms that ignored sleep events and abandoned measurements produce no extra completion.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

    parameter int unsigned RISE_W = 16;

    typedef logic [RISE_W-1:0] rise_t;

    typedef enum logic [1:0] {
        GATE_RSVD0   = 2'b00,
        GATE_L2_ONLY = 2'b01,
        GATE_HINT_L2 = 2'b10,
        GATE_RSVD3   = 2'b11
    } gate_policy_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'b00,
        MS_ARMED = 2'b01,
        MS_COUNT = 2'b10
    } meas_state_e;

    typedef struct packed {
        rise_t cycles;
        logic  timed_out;
    } meas_result_t;

    function automatic rise_t sat_inc(rise_t v);
        return (v == '1) ? v : v + rise_t'(1);
    endfunction

    function automatic gate_policy_e pick_policy(rise_t r, rise_t lo, rise_t hi,
                                                 gate_policy_e cur);
        if (r < lo)
            return GATE_HINT_L2;
        else if (r > hi)
            return GATE_L2_ONLY;
        else
            return cur;
    endfunction

endpackage

// File: rtl/lrm_sync.sv
module lrm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lrm_counter.sv
module lrm_counter
    import lrm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  en_i,
    output rise_t cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (en_i)
            cnt_o <= sat_inc(cnt_o);
    end
endmodule

// File: rtl/lrm_policy.sv
module lrm_policy
    import lrm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_i,
    input  logic         force_long_i,
    input  rise_t        rise_i,
    input  rise_t        lo_i,
    input  rise_t        hi_i,
    output gate_policy_e policy_o
);
    always_ff @(posedge clk) begin
        if (rst)
            policy_o <= GATE_L2_ONLY;
        else if (force_long_i)
            policy_o <= GATE_L2_ONLY;
        else if (upd_i)
            policy_o <= pick_policy(rise_i, lo_i, hi_i, policy_o);
    end
endmodule

// File: rtl/lrm_rise_monitor.sv
module lrm_rise_monitor
    import lrm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sleep_enter_i,
    input  logic              cmp_async_i,
    input  logic [RISE_W-1:0] timeout_lim_i,
    input  logic [RISE_W-1:0] thr_lo_i,
    input  logic [RISE_W-1:0] thr_hi_i,
    output logic [RISE_W-1:0] rise_cycles_o,
    output logic              valid_o,
    output logic              timeout_o,
    output logic [1:0]        strategy_o
);
    meas_state_e  state_q, state_d;
    meas_result_t res_q;
    logic         valid_q;
    logic         cmp_rise;
    rise_t        cnt;
    logic         in_count;
    logic         done_edge;
    logic         done_limit;
    gate_policy_e policy;

    lrm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cmp_async_i),
        .rise_o  (cmp_rise)
    );

    // Counter is held at zero outside a measurement, counts while measuring.
    lrm_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (!in_count),
        .en_i  (in_count),
        .cnt_o (cnt)
    );

    always_comb begin
        in_count   = (state_q == MS_COUNT);
        done_edge  = in_count && !start_i && cmp_rise;
        done_limit = in_count && !start_i && !cmp_rise && (cnt == timeout_lim_i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE:  if (start_i) state_d = MS_ARMED;
            MS_ARMED: if (!start_i && sleep_enter_i) state_d = MS_COUNT;
            MS_COUNT: begin
                if (start_i)                      state_d = MS_ARMED;
                else if (done_edge || done_limit) state_d = MS_IDLE;
            end
            default:  state_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || start_i)
            res_q <= '0;
        else if (done_edge)
            res_q <= '{cycles: cnt, timed_out: 1'b0};
        else if (done_limit)
            res_q <= '{cycles: cnt, timed_out: 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= done_edge || done_limit;
    end

    lrm_policy u_policy (
        .clk          (clk),
        .rst          (rst),
        .upd_i        (done_edge),
        .force_long_i (done_limit),
        .rise_i       (cnt),
        .lo_i         (thr_lo_i),
        .hi_i         (thr_hi_i),
        .policy_o     (policy)
    );

    assign rise_cycles_o = res_q.cycles;
    assign timeout_o     = res_q.timed_out;
    assign valid_o       = valid_q;
    assign strategy_o    = policy;
endmodule

// File: rtl/lrm_checker.sv
module lrm_checker
    import lrm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [RISE_W-1:0] thr_lo_i,
    input logic [RISE_W-1:0] thr_hi_i,
    input logic [RISE_W-1:0] rise_cycles_o,
    input logic              valid_o,
    input logic              timeout_o,
    input logic [1:0]        strategy_o
);
    a_r10_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r11_strategy_only_on_valid: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(strategy_o));

    a_r5_timeout_long: assert property (@(posedge clk) disable iff (rst)
        (valid_o && timeout_o) |-> (strategy_o == 2'b01));

    a_r6_short_hint: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !timeout_o && (rise_cycles_o < $past(thr_lo_i)))
            |-> (strategy_o == 2'b10));

    a_r8_band_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !timeout_o && (rise_cycles_o >= $past(thr_lo_i))
            && (rise_cycles_o <= $past(thr_hi_i))) |-> $stable(strategy_o));

    a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (valid_o || ($stable(rise_cycles_o) && $stable(timeout_o))));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
        (strategy_o == 2'b01) || (strategy_o == 2'b10));
endmodule

bind lrm_rise_monitor lrm_checker i_lrm_checker (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .thr_lo_i      (thr_lo_i),
    .thr_hi_i      (thr_hi_i),
    .rise_cycles_o (rise_cycles_o),
    .valid_o       (valid_o),
    .timeout_o     (timeout_o),
    .strategy_o    (strategy_o)
);

// File: tb/test_lrm_rise_monitor.sv
module test_lrm_rise_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        sleep_enter_i = 1'b0;
    logic        cmp_async_i = 1'b0;
    logic [15:0] timeout_lim_i = 16'd1000;
    logic [15:0] thr_lo_i = 16'd20;
    logic [15:0] thr_hi_i = 16'd40;
    logic [15:0] rise_cycles_o;
    logic        valid_o;
    logic        timeout_o;
    logic [1:0]  strategy_o;

    int n_chk = 0;
    int n_bad = 0;
    int vcount = 0;

    always #2 clk = ~clk;

    lrm_rise_monitor i_lrm_rise_monitor (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .sleep_enter_i (sleep_enter_i),
        .cmp_async_i   (cmp_async_i),
        .timeout_lim_i (timeout_lim_i),
        .thr_lo_i      (thr_lo_i),
        .thr_hi_i      (thr_hi_i),
        .rise_cycles_o (rise_cycles_o),
        .valid_o       (valid_o),
        .timeout_o     (timeout_o),
        .strategy_o    (strategy_o)
    );

    always @(negedge clk) if (valid_o) vcount++;

    // {comparator delay N, expected rise, expected policy}; band 20..40
    localparam logic [33:0] VEC [9] = '{
        {16'd9,  16'd10, 2'b10},
        {16'd29, 16'd30, 2'b10},
        {16'd59, 16'd60, 2'b01},
        {16'd24, 16'd25, 2'b01},
        {16'd19, 16'd20, 2'b01},
        {16'd18, 16'd19, 2'b10},
        {16'd39, 16'd40, 2'b10},
        {16'd40, 16'd41, 2'b01},
        {16'd1,  16'd2,  2'b10}
    };

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic arm_and_sleep();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) begin start_i = 1'b0; sleep_enter_i = 1'b1; end
        @(negedge clk) sleep_enter_i = 1'b0;
    endtask

    task automatic settle_low();
        cmp_async_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int prev;
        int v0;
        repeat (5) @(negedge clk);
        chk("R1", "rise in reset", int'(rise_cycles_o), 0);
        chk("R1", "policy in reset", int'(strategy_o), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rise", int'(rise_cycles_o), 0);
        chk("R1", "valid", int'(valid_o), 0);
        chk("R1", "timeout", int'(timeout_o), 0);
        chk("R1", "policy", int'(strategy_o), 1);

        // R2: sleep event with no start is ignored
        v0 = vcount;
        @(negedge clk) sleep_enter_i = 1'b1;
        @(negedge clk) begin sleep_enter_i = 1'b0; cmp_async_i = 1'b1; end
        repeat (8) @(negedge clk);
        chk("R2", "valid pulses", vcount - v0, 0);
        chk("R2", "rise", int'(rise_cycles_o), 0);
        chk("R2", "policy", int'(strategy_o), 1);
        settle_low();

        // Table of measurements: R3, R6, R7, R8, R10, R11
        prev = 1;
        for (int i = 0; i < 9; i++) begin
            int    n    = int'(VEC[i][33:18]);
            int    er   = int'(VEC[i][17:2]);
            int    es   = int'(VEC[i][1:0]);
            string preq = (es == prev) ? "R8" : ((es == 2) ? "R6" : "R7");
            arm_and_sleep();
            repeat (n - 1) @(negedge clk);
            cmp_async_i = 1'b1;
            repeat (2) @(negedge clk);
            chk("R3", "valid early", int'(valid_o), 0);
            chk("R11", "policy before valid", int'(strategy_o), prev);
            @(negedge clk);
            chk("R3", "valid due", int'(valid_o), 1);
            chk("R3", "rise", int'(rise_cycles_o), er);
            chk("R3", "timeout", int'(timeout_o), 0);
            chk(preq, "policy", int'(strategy_o), es);
            @(negedge clk);
            chk("R10", "valid width", int'(valid_o), 0);
            settle_low();
            prev = es;
        end

        // R5: timeout with limit 20, policy was 2'b10
        timeout_lim_i = 16'd20;
        v0 = vcount;
        arm_and_sleep();
        repeat (20) @(negedge clk);
        chk("R5", "valid early", int'(valid_o), 0);
        @(negedge clk);
        chk("R5", "valid due", int'(valid_o), 1);
        chk("R5", "timeout", int'(timeout_o), 1);
        chk("R5", "rise", int'(rise_cycles_o), 20);
        chk("R5", "policy", int'(strategy_o), 1);
        repeat (5) @(negedge clk);
        chk("R9", "held rise", int'(rise_cycles_o), 20);
        chk("R9", "held timeout", int'(timeout_o), 1);
        chk("R10", "one pulse", vcount - v0, 1);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk("R9", "cleared rise", int'(rise_cycles_o), 0);
        chk("R9", "cleared timeout", int'(timeout_o), 0);

        // R4: comparator already high does not end the measurement
        cmp_async_i = 1'b1;
        repeat (4) @(negedge clk);
        arm_and_sleep();
        repeat (20) @(negedge clk);
        chk("R4", "no early end", int'(valid_o), 0);
        @(negedge clk);
        chk("R4", "timeout", int'(timeout_o), 1);
        chk("R4", "rise", int'(rise_cycles_o), 20);
        settle_low();

        // R9: restart abandons a running measurement
        timeout_lim_i = 16'd1000;
        v0 = vcount;
        arm_and_sleep();
        repeat (5) @(negedge clk);
        arm_and_sleep();
        repeat (8) @(negedge clk);
        cmp_async_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "restart rise", int'(rise_cycles_o), 10);
        chk("R6", "restart policy", int'(strategy_o), 2);
        @(negedge clk);
        chk("R9", "restart pulses", vcount - v0, 1);
        settle_low();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule